// File: doc/BRIEF.md
# Branch Target Computation Unit

This unit works out the new program-counter and link-register values for the branch instructions of a 16-bit compressed instruction set. Each request carries a branch kind, the raw immediate field, a 4-bit condition, the N/Z/C/V flags, the current PC value (instruction address plus pipeline offset), the address of the next instruction, the present link-register value and a general register value for register-indirect branches. One clock later the unit presents a taken strobe with the new PC, an optional link-register write and an optional instruction-set state write. Pipeline flushing and fetch belong to the surrounding core.

A long call is split over two consecutive halfwords. The first half leaves a partial target in the link register. The second half adds its low offset to that value, jumps, and turns the link register into the return address. The register branch takes its instruction-set state from bit 0 of the register value.

Top module: `branch_target_unit`

## Requirements
- R1: Results appear one clock after a request. `out_valid` is high exactly in the cycle after `req_valid`. Whenever `out_valid` is low, and after reset, every output is 0. `pc_out` is 0 whenever `taken` is low, `lr_out` is 0 whenever `lr_we` is low, and `state_bit` is 0 whenever `state_we` is low.
- R2: Kind 0 (near branch): `taken`=1 and `pc_out` = `pc_cur` + sign-extended `imm[10:0]`×2, with bit 0 cleared. No link or state write.
- R3: Kind 1 (conditional branch): when the condition passes, `taken`=1 and `pc_out` = `pc_cur` + sign-extended `imm[7:0]`×2, with bit 0 cleared. When it fails, `taken`=0 and nothing is written.
- R4: The condition codes use the flags `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always; 15 never.
- R5: Kind 2 (long call, first half): `lr_we`=1 and `lr_out` = `pc_cur` + (sign-extended `imm[10:0]` shifted left by 12). `taken`=0.
- R6: Kind 3 (long call, second half): `taken`=1, `pc_out` = `link_in` + zero-extended `imm[10:0]`×2 with bit 0 cleared, `lr_we`=1 and `lr_out` = `next_addr` with bit 0 set.
- R7: Kind 4 (register exchange): `taken`=1, `pc_out` = `reg_val` with bit 0 cleared, `state_we`=1 and `state_bit` = `reg_val[0]`.
- R8: Kinds 5, 6 and 7 are reserved. They produce `out_valid`=1 with `taken`, `lr_we` and `state_we` all 0.
- R9: The flags and the condition field have no effect on kinds other than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| kind | input | 3 | Branch kind (0 near, 1 conditional, 2 long first, 3 long second, 4 exchange) |
| imm | input | 11 | Raw immediate field |
| cond | input | 4 | Condition code |
| flags | input | 4 | N, Z, C, V (bit 3 down to bit 0) |
| pc_cur | input | 32 | Current PC value including pipeline offset |
| next_addr | input | 32 | Address of the next instruction |
| link_in | input | 32 | Present link-register value |
| reg_val | input | 32 | Register operand for the exchange branch |
| out_valid | output | 1 | Result present |
| taken | output | 1 | PC must be replaced |
| pc_out | output | 32 | New PC |
| lr_we | output | 1 | Link-register write |
| lr_out | output | 32 | Link-register value |
| state_we | output | 1 | Instruction-set state write |
| state_bit | output | 1 | New instruction-set state |

## Verification
The assertions take `pc_cur`, `link_in` and `next_addr` as plain values with no alignment promise. For this reason the evenness of `pc_out` is checked as the unit's own duty and is not assumed from the inputs. They also assume `req_valid` is never unknown once reset is released. The stimulus drives every input on the falling edge so that each request is held for the whole cycle, sends back-to-back requests as well as isolated ones, and passes odd PC and link values to reach the alignment rule. It leaves `req_valid` low during reset.

// File: rtl/branch_target_pkg.sv
package branch_target_pkg;

  typedef enum logic [2:0] {
    BK_NEAR = 3'd0,
    BK_COND = 3'd1,
    BK_LHI  = 3'd2,
    BK_LLO  = 3'd3,
    BK_XCHG = 3'd4
  } br_kind_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  // Condition test over N Z C V, one code per line of R4.
  function automatic logic cond_holds(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v;
    n = f[FLAG_N];
    z = f[FLAG_Z];
    c = f[FLAG_C];
    v = f[FLAG_V];
    unique case (code)
      4'd0:  cond_holds = z;
      4'd1:  cond_holds = !z;
      4'd2:  cond_holds = c;
      4'd3:  cond_holds = !c;
      4'd4:  cond_holds = n;
      4'd5:  cond_holds = !n;
      4'd6:  cond_holds = v;
      4'd7:  cond_holds = !v;
      4'd8:  cond_holds = c && !z;
      4'd9:  cond_holds = !c || z;
      4'd10: cond_holds = (n == v);
      4'd11: cond_holds = (n != v);
      4'd12: cond_holds = !z && (n == v);
      4'd13: cond_holds = z || (n != v);
      4'd14: cond_holds = 1'b1;
      default: cond_holds = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import branch_target_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       pass
);
  always_comb pass = cond_holds(cond, flags);
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
  parameter int AW      = 32,
  parameter int LONG_W  = 11,
  parameter int SHORT_W = 8
) (
  input  logic [LONG_W-1:0] imm,
  input  logic [AW-1:0]     pc_cur,
  input  logic [AW-1:0]     next_addr,
  input  logic [AW-1:0]     link_in,
  input  logic [AW-1:0]     reg_val,
  output logic [AW-1:0]     near_tgt,
  output logic [AW-1:0]     cond_tgt,
  output logic [AW-1:0]     hi_link,
  output logic [AW-1:0]     lo_tgt,
  output logic [AW-1:0]     lo_link,
  output logic [AW-1:0]     xchg_tgt
);
  localparam int HI_SHIFT = LONG_W + 1;

  function automatic logic [AW-1:0] sext_long(input logic [LONG_W-1:0] f);
    return {{(AW-LONG_W){f[LONG_W-1]}}, f};
  endfunction

  function automatic logic [AW-1:0] sext_short(input logic [SHORT_W-1:0] f);
    return {{(AW-SHORT_W){f[SHORT_W-1]}}, f};
  endfunction

  function automatic logic [AW-1:0] zext_long(input logic [LONG_W-1:0] f);
    return {{(AW-LONG_W){1'b0}}, f};
  endfunction

  function automatic logic [AW-1:0] even(input logic [AW-1:0] a);
    return {a[AW-1:1], 1'b0};
  endfunction

  always_comb begin
    near_tgt = even(pc_cur + (sext_long(imm) << 1));
    cond_tgt = even(pc_cur + (sext_short(imm[SHORT_W-1:0]) << 1));
    hi_link  = pc_cur + (sext_long(imm) << HI_SHIFT);
    lo_tgt   = even(link_in + (zext_long(imm) << 1));
    lo_link  = {next_addr[AW-1:1], 1'b1};
    xchg_tgt = even(reg_val);
  end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import branch_target_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LONG_W  = 11,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        kind,
  input  logic [LONG_W-1:0] imm,
  input  logic [3:0]        cond,
  input  logic [3:0]        flags,
  input  logic [AW-1:0]     pc_cur,
  input  logic [AW-1:0]     next_addr,
  input  logic [AW-1:0]     link_in,
  input  logic [AW-1:0]     reg_val,
  output logic              out_valid,
  output logic              taken,
  output logic [AW-1:0]     pc_out,
  output logic              lr_we,
  output logic [AW-1:0]     lr_out,
  output logic              state_we,
  output logic              state_bit
);
  logic          cond_ok;
  logic [AW-1:0] near_tgt, cond_tgt, hi_link, lo_tgt, lo_link, xchg_tgt;
  logic          nx_taken, nx_lr_we, nx_state_we, nx_state_bit;
  logic [AW-1:0] nx_pc, nx_lr;
  br_kind_e      k;

  branch_cond_eval u_cond (
    .cond (cond),
    .flags(flags),
    .pass (cond_ok)
  );

  branch_target_calc #(.AW(AW), .LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_calc (
    .imm      (imm),
    .pc_cur   (pc_cur),
    .next_addr(next_addr),
    .link_in  (link_in),
    .reg_val  (reg_val),
    .near_tgt (near_tgt),
    .cond_tgt (cond_tgt),
    .hi_link  (hi_link),
    .lo_tgt   (lo_tgt),
    .lo_link  (lo_link),
    .xchg_tgt (xchg_tgt)
  );

  always_comb begin
    k            = br_kind_e'(kind);
    nx_taken     = 1'b0;
    nx_pc        = '0;
    nx_lr_we     = 1'b0;
    nx_lr        = '0;
    nx_state_we  = 1'b0;
    nx_state_bit = 1'b0;
    if (req_valid) begin
      case (k)
        BK_NEAR: begin
          nx_taken = 1'b1;
          nx_pc    = near_tgt;
        end
        BK_COND: begin
          nx_taken = cond_ok;
          nx_pc    = cond_ok ? cond_tgt : '0;
        end
        BK_LHI: begin
          nx_lr_we = 1'b1;
          nx_lr    = hi_link;
        end
        BK_LLO: begin
          nx_taken = 1'b1;
          nx_pc    = lo_tgt;
          nx_lr_we = 1'b1;
          nx_lr    = lo_link;
        end
        BK_XCHG: begin
          nx_taken     = 1'b1;
          nx_pc        = xchg_tgt;
          nx_state_we  = 1'b1;
          nx_state_bit = reg_val[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      pc_out    <= '0;
      lr_we     <= 1'b0;
      lr_out    <= '0;
      state_we  <= 1'b0;
      state_bit <= 1'b0;
    end else begin
      out_valid <= req_valid;
      taken     <= nx_taken;
      pc_out    <= nx_pc;
      lr_we     <= nx_lr_we;
      lr_out    <= nx_lr;
      state_we  <= nx_state_we;
      state_bit <= nx_state_bit;
    end
  end
endmodule

// File: rtl/branch_target_unit_chk.sv
module branch_target_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    kind,
  input logic [3:0]    cond,
  input logic          cond_ok,
  input logic          out_valid,
  input logic          taken,
  input logic [AW-1:0] pc_out,
  input logic          lr_we,
  input logic [AW-1:0] lr_out,
  input logic          state_we
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> !taken && !lr_we && !state_we); // R1
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n) taken |-> !pc_out[0]); // R2
  AST_COND_GATE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && kind == 3'd1) |=> (taken == $past(cond_ok))); // R3
  AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && kind == 3'd1 && cond == 4'd14) |=> taken); // R4
  AST_COND_NEVER: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && kind == 3'd1 && cond == 4'd15) |=> !taken); // R4
  AST_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && kind == 3'd2) |=> lr_we && !taken); // R5
  AST_RETURN_ODD: assert property (@(posedge clk) disable iff (!rst_n) (lr_we && taken) |-> lr_out[0]); // R6
  AST_STATE_WITH_JUMP: assert property (@(posedge clk) disable iff (!rst_n) state_we |-> taken); // R7
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && kind >= 3'd5) |=> !taken && !lr_we && !state_we); // R8
endmodule

bind branch_target_unit branch_target_unit_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .kind     (kind),
  .cond     (cond),
  .cond_ok  (cond_ok),
  .out_valid(out_valid),
  .taken    (taken),
  .pc_out   (pc_out),
  .lr_we    (lr_we),
  .lr_out   (lr_out),
  .state_we (state_we)
);

// File: tb/branch_target_unit_test.sv
`timescale 1ns/1ps
module branch_target_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  kind = '0;
  logic [10:0] imm = '0;
  logic [3:0]  cond = '0;
  logic [3:0]  flags = '0;
  logic [31:0] pc_cur = '0, next_addr = '0, link_in = '0, reg_val = '0;
  logic        out_valid, taken, lr_we, state_we, state_bit;
  logic [31:0] pc_out, lr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        tk;
    logic [31:0] pc;
    logic        lw;
    logic [31:0] lr;
    logic        sw;
    logic        sb;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  branch_target_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind), .imm(imm),
    .cond(cond), .flags(flags), .pc_cur(pc_cur), .next_addr(next_addr),
    .link_in(link_in), .reg_val(reg_val), .out_valid(out_valid), .taken(taken),
    .pc_out(pc_out), .lr_we(lr_we), .lr_out(lr_out), .state_we(state_we),
    .state_bit(state_bit)
  );

  // Condition rule of R4, grouped in pairs: even code tests, odd code inverts.
  function automatic logic pass_ref(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, base;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: return (c == 4'd14);
    endcase
    return c[0] ? ~base : base;
  endfunction

  function automatic exp_t model(input logic [2:0] kd, input logic [10:0] im,
      input logic [3:0] c, input logic [3:0] f, input logic [31:0] pc,
      input logic [31:0] nx, input logic [31:0] ln, input logic [31:0] rg);
    exp_t e;
    int signed d11, d8;
    d11 = $signed(im);
    d8  = $signed(im[7:0]);
    e = '{1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, ""};
    case (kd)
      3'd0: begin e.tk = 1; e.pc = (pc + 32'(d11 * 2)) & ~32'd1; end
      3'd1: if (pass_ref(c, f)) begin e.tk = 1; e.pc = (pc + 32'(d8 * 2)) & ~32'd1; end
      3'd2: begin e.lw = 1; e.lr = pc + 32'(d11 * 4096); end
      3'd3: begin e.tk = 1; e.pc = (ln + 32'(im) * 2) & ~32'd1; e.lw = 1; e.lr = nx | 32'd1; end
      3'd4: begin e.tk = 1; e.pc = rg & ~32'd1; e.sw = 1; e.sb = rg[0]; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic send(input logic [2:0] kd, input logic [10:0] im, input logic [3:0] c,
      input logic [3:0] f, input logic [31:0] pc, input logic [31:0] nx,
      input logic [31:0] ln, input logic [31:0] rg, input string tag);
    exp_t e;
    req_valid = 1; kind = kd; imm = im; cond = c; flags = f;
    pc_cur = pc; next_addr = nx; link_in = ln; reg_val = rg;
    e = model(kd, im, c, f, pc, nx, ln, rg);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 0;
    @(negedge clk);
  endtask

  // Monitor: compares each result against the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result: actual out_valid=1 expected 0");
      end else begin
        e = q.pop_front();
        if (taken !== e.tk || pc_out !== e.pc || lr_we !== e.lw || lr_out !== e.lr ||
            state_we !== e.sw || state_bit !== e.sb) begin
          errors++;
          $display("FAIL %s: actual tk=%0b pc=%h lw=%0b lr=%h sw=%0b sb=%0b expected tk=%0b pc=%h lw=%0b lr=%h sw=%0b sb=%0b",
            e.tag, taken, pc_out, lr_we, lr_out, state_we, state_bit,
            e.tk, e.pc, e.lw, e.lr, e.sw, e.sb);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || taken !== 0 || pc_out !== 0 || lr_we !== 0 || lr_out !== 0 ||
        state_we !== 0 || state_bit !== 0) begin
      errors++;
      $display("FAIL R1 reset: actual valid=%0b pc=%h lr=%h expected all zero", out_valid, pc_out, lr_out);
    end
    rst_n = 1;
    @(negedge clk);

    // R2 near, forward and backward, odd PC
    send(3'd0, 11'h005, 4'd0, 4'h0, 32'h0000_1004, 32'h1002, 32'h0, 32'h0, "R2 near fwd");
    send(3'd0, 11'h7FE, 4'd0, 4'h0, 32'h0000_1004, 32'h1002, 32'h0, 32'h0, "R2 near back");
    send(3'd0, 11'h400, 4'd0, 4'h0, 32'h0000_1001, 32'h1002, 32'h0, 32'h0, "R2 near min odd pc");
    // R9 flags and condition have no effect on near
    send(3'd0, 11'h005, 4'd15, 4'hF, 32'h0000_1004, 32'h1002, 32'h0, 32'h0, "R9 near flags ignored");
    idle();
    // R3 / R4 conditional
    send(3'd1, 11'h010, 4'd0, 4'b0100, 32'h0000_2000, 32'h0, 32'h0, 32'h0, "R3 EQ taken");
    send(3'd1, 11'h010, 4'd0, 4'b0000, 32'h0000_2000, 32'h0, 32'h0, 32'h0, "R3 EQ not taken");
    send(3'd1, 11'h7F0, 4'd14, 4'b0000, 32'h0000_2000, 32'h0, 32'h0, 32'h0, "R3 AL backward upper bits ignored");
    send(3'd1, 11'h010, 4'd15, 4'hF, 32'h0000_2000, 32'h0, 32'h0, 32'h0, "R4 NV never");
    for (int c = 0; c < 14; c++) begin
      for (int f = 0; f < 16; f += 5)
        send(3'd1, 11'h004, 4'(c), 4'(f), 32'h0000_3000, 32'h0, 32'h0, 32'h0, "R4 cond sweep");
    end
    idle();
    // R5 / R6 long call pair
    send(3'd2, 11'h001, 4'd0, 4'h0, 32'h0000_4004, 32'h0, 32'h0, 32'h0, "R5 first half fwd");
    send(3'd2, 11'h7FF, 4'd0, 4'h0, 32'h0000_4004, 32'h0, 32'h0, 32'h0, "R5 first half back");
    send(3'd3, 11'h7FF, 4'd0, 4'h0, 32'h0000_4006, 32'h0000_4004, 32'h0000_5004, 32'h0, "R6 second half max");
    send(3'd3, 11'h003, 4'd0, 4'h0, 32'h0, 32'h0000_4003, 32'h0000_5001, 32'h0, "R6 odd link");
    send(3'd3, 11'h003, 4'd1, 4'hA, 32'h0, 32'h0000_4003, 32'h0000_5001, 32'h0, "R9 second half flags ignored");
    // R7 exchange
    send(3'd4, 11'h0, 4'd0, 4'h0, 32'h0, 32'h0, 32'h0, 32'h0800_0101, "R7 exchange odd");
    send(3'd4, 11'h0, 4'd15, 4'hF, 32'h0, 32'h0, 32'h0, 32'h0800_0200, "R7 exchange even");
    // R8 reserved
    send(3'd5, 11'h7FF, 4'd14, 4'h0, 32'h1234, 32'h1, 32'h1, 32'h1, "R8 reserved 5");
    send(3'd7, 11'h7FF, 4'd14, 4'h0, 32'h1234, 32'h1, 32'h1, 32'h1, "R8 reserved 7");
    idle();
    idle();
    checks++;
    if (out_valid !== 0 || taken !== 0 || lr_we !== 0 || state_we !== 0) begin
      errors++;
      $display("FAIL R1 idle: actual valid=%0b tk=%0b expected 0 0", out_valid, taken);
    end
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule